// File: doc/BRIEF.md
# Floating-Point Register File with Paired Double Access

This block is the floating-point register file of a processor core. It is separate from the integer registers and holds thirty-two 32-bit words. Every port can work in one of two widths. In single width it moves one 32-bit word. In double width it moves a 64-bit value held in an even-odd pair of words, and the access is named by the even index. Within a pair, the even word holds the low half of the double and the odd word holds the high half. Because of this, a single-precision view and a double-precision view of the same storage always agree.

There are two read ports and one write port. Reads are combinational. A write lands on the rising clock edge. A write issued in the same cycle as a read that overlaps it is forwarded word by word to the read port, so an instruction that consumes a value in the cycle it is written sees the new data. The write port serves both single-width and double-width loads. A double-width access with an odd index is flagged as illegal and does nothing.

Top module: `fp_pair_regfile`

## Requirements
- R1: A single-width write (`wr_wide`=0) with `wr_en`=1 stores `wr_data[31:0]` into word `wr_sel` at the clock edge. A single-width read returns that word in bits [31:0] with bits [63:32] zero.
- R2: A double-width write (`wr_wide`=1) at an even `wr_sel` stores `wr_data[31:0]` into word `wr_sel` and `wr_data[63:32]` into word `wr_sel`+1.
- R3: A double-width read at an even index returns {word index+1, word index}.
- R4: A double-width write with an odd `wr_sel` raises `wr_bad` in the same cycle and changes no word.
- R5: A double-width read with an odd index raises that port's bad flag and returns all zeros.
- R6: A single-width write to one word of a pair leaves the other word of that pair unchanged.
- R7: A read that overlaps a same-cycle legal write returns the value being written, word by word. This includes a single-width write that hits one half of a double-width read.
- R8: While `rst` is high at a clock edge, every word is cleared to zero.
- R9: The two read ports act independently and can read different words or pairs in the same cycle.
- R10: With `wr_en`=0, no word changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | Write width: 0 single, 1 double |
| wr_sel | input | 5 | Write word index (even for double) |
| wr_data | input | 64 | Write data; single uses [31:0] |
| wr_bad | output | 1 | Odd-index double write rejected |
| a_sel | input | 5 | Read port A index |
| a_wide | input | 1 | Read port A width |
| a_data | output | 64 | Read port A data |
| a_bad | output | 1 | Read port A odd-index double |
| b_sel | input | 5 | Read port B index |
| b_wide | input | 1 | Read port B width |
| b_data | output | 64 | Read port B data |
| b_bad | output | 1 | Read port B odd-index double |

## Verification
The assertions watch the storage on every cycle. They check that a rejected write leaves all words stable, that a single write never touches its partner word, and that a double write lands both halves in the right order. They also check that reset clears the array, that single-width forwarding reaches port A, and that a bad read returns zeros. Other behaviours only show through the bench's scenarios against its cycle model. These are partial-overlap forwarding between widths, independent traffic on the two read ports, and a long run of mixed widths and indices.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic {WIDTH_SINGLE = 1'b0, WIDTH_DOUBLE = 1'b1} width_e;

  // A double access must name the even word of its pair.
  function automatic logic pair_ok(input logic wide, input logic sel_lsb);
    return !(wide && sel_lsb);
  endfunction

  // Does an access at base (with given width) cover word slot?
  function automatic logic slot_hit(input logic wide, input int base, input int slot);
    return (slot == base) || (wide && (slot == base + 1));
  endfunction

  // Which half of the 64-bit write bus feeds word slot.
  function automatic logic takes_high(input logic wide, input int slot);
    return wide && ((slot % 2) == 1);
  endfunction
endpackage

// File: rtl/fprf_wr_decode.sv
module fprf_wr_decode
  import fprf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    wr_wide,
  input  logic [IW-1:0]           wr_sel,
  input  logic [2*W-1:0]          wr_data,
  output logic [NREG-1:0]         slot_we,
  output logic [NREG-1:0][W-1:0]  slot_wd,
  output logic                    bad
);
  logic legal;
  assign legal = pair_ok(wr_wide, wr_sel[0]);
  assign bad   = wr_en && wr_wide && !legal;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign slot_we[g] = wr_en && legal && slot_hit(wr_wide, int'(wr_sel), g);
    assign slot_wd[g] = takes_high(wr_wide, g) ? wr_data[2*W-1:W] : wr_data[W-1:0];
  end

  // R6: a single-width write enables exactly one word
  p_single_one_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide) |-> $onehot(slot_we));
  // R2: a legal double write enables exactly two words
  p_double_two_slots_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && !wr_sel[0]) |-> ($countones(slot_we) == 2));
  // R10: no request, no enables
  p_idle_no_enable_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (slot_we == '0));
endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         slot_we,
  input  logic [NREG-1:0][W-1:0]  slot_wd,
  output logic [NREG-1:0][W-1:0]  q
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)             q[g] <= '0;
      else if (slot_we[g]) q[g] <= slot_wd[g];
    end
  end
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port
  import fprf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IW-1:0]           sel,
  input  logic                    wide,
  input  logic [NREG-1:0][W-1:0]  q,
  input  logic [NREG-1:0]         slot_we,
  input  logic [NREG-1:0][W-1:0]  slot_wd,
  output logic [2*W-1:0]          data,
  output logic                    bad
);
  logic [IW-1:0] lo_sel, hi_sel;
  logic [W-1:0]  lo_word, hi_word;

  assign lo_sel  = sel;
  assign hi_sel  = sel | IW'(1);
  // per-word forwarding of a same-cycle write
  assign lo_word = slot_we[lo_sel] ? slot_wd[lo_sel] : q[lo_sel];
  assign hi_word = slot_we[hi_sel] ? slot_wd[hi_sel] : q[hi_sel];
  assign bad     = !pair_ok(wide, sel[0]);

  always_comb begin
    if (bad)       data = '0;
    else if (wide) data = {hi_word, lo_word};
    else           data = {{W{1'b0}}, lo_word};
  end

  // R5: a rejected read drives zeros
  p_bad_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    bad |-> (data == '0));
  // R1: single read has a zero upper half
  p_single_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (data[2*W-1:W] == '0));
endmodule

// File: rtl/fp_pair_regfile.sv
module fp_pair_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_wide,
  input  logic [IW-1:0]   wr_sel,
  input  logic [2*W-1:0]  wr_data,
  output logic            wr_bad,
  input  logic [IW-1:0]   a_sel,
  input  logic            a_wide,
  output logic [2*W-1:0]  a_data,
  output logic            a_bad,
  input  logic [IW-1:0]   b_sel,
  input  logic            b_wide,
  output logic [2*W-1:0]  b_data,
  output logic            b_bad
);
  logic [NREG-1:0]         slot_we;
  logic [NREG-1:0][W-1:0]  slot_wd;
  logic [NREG-1:0][W-1:0]  q;
  logic [1:0][IW-1:0]      rd_sel;
  logic [1:0]              rd_wide, rd_bad;
  logic [1:0][2*W-1:0]     rd_data;

  fprf_wr_decode #(.NREG(NREG), .W(W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_data(wr_data), .slot_we(slot_we), .slot_wd(slot_wd), .bad(wr_bad));

  fprf_store #(.NREG(NREG), .W(W)) u_store (
    .clk(clk), .rst(rst), .slot_we(slot_we), .slot_wd(slot_wd), .q(q));

  assign rd_sel  = {b_sel, a_sel};
  assign rd_wide = {b_wide, a_wide};

  for (genvar p = 0; p < 2; p++) begin : g_rd
    fprf_rd_port #(.NREG(NREG), .W(W)) u_port (
      .clk(clk), .rst(rst), .sel(rd_sel[p]), .wide(rd_wide[p]), .q(q),
      .slot_we(slot_we), .slot_wd(slot_wd), .data(rd_data[p]), .bad(rd_bad[p]));
  end

  assign a_data = rd_data[0];
  assign a_bad  = rd_bad[0];
  assign b_data = rd_data[1];
  assign b_bad  = rd_bad[1];

  // R8: reset clears every word
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (q == '0));
  // R4: a rejected write leaves storage untouched
  p_bad_write_hold_r4: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> $stable(q));
  // R6: partner word of a single write is kept
  p_partner_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide) |=> (q[$past(wr_sel) ^ IW'(1)] == $past(q[wr_sel ^ IW'(1)])));
  // R2: double write lands low half in even word, high half in odd word
  p_double_order_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && !wr_sel[0]) |=>
      ({q[$past(wr_sel) | IW'(1)], q[$past(wr_sel)]} == $past(wr_data)));
  // R7: same-cycle single write is forwarded to port A
  p_forward_a_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide && !a_wide && (a_sel == wr_sel)) |->
      (a_data == {{W{1'b0}}, wr_data[W-1:0]}));
  // R10: idle write port keeps storage
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: tb/test_fp_pair_regfile.sv
`timescale 1ns/1ps
module test_fp_pair_regfile;
  logic        clk = 0;
  logic        rst;
  logic        wr_en, wr_wide, wr_bad;
  logic [4:0]  wr_sel, a_sel, b_sel;
  logic [63:0] wr_data, a_data, b_data;
  logic        a_wide, b_wide, a_bad, b_bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m [32];

  always #5 clk = ~clk;

  fp_pair_regfile i_fp_pair_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_bad(wr_bad), .a_sel(a_sel), .a_wide(a_wide),
    .a_data(a_data), .a_bad(a_bad), .b_sel(b_sel), .b_wide(b_wide),
    .b_data(b_data), .b_bad(b_bad));

  function automatic bit wr_ok();
    return wr_en && !(wr_wide && wr_sel[0]);
  endfunction

  // value a word will show this cycle, including forwarding
  function automatic logic [31:0] seen(int s);
    int base = wr_sel;
    if (wr_ok() && s == base) return wr_data[31:0];
    if (wr_ok() && wr_wide && s == base + 1) return wr_data[63:32];
    return m[s];
  endfunction

  function automatic logic [63:0] expect_rd(logic [4:0] i, logic wd);
    int k = i;
    if (wd && i[0]) return 64'd0;
    if (wd) return {seen(k + 1), seen(k)};
    return {32'd0, seen(k)};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic setw(logic en, logic wd, logic [4:0] s, logic [63:0] d);
    wr_en = en; wr_wide = wd; wr_sel = s; wr_data = d;
  endtask

  task automatic setr(logic [4:0] ai, logic aw, logic [4:0] bi, logic bw);
    a_sel = ai; a_wide = aw; b_sel = bi; b_wide = bw;
  endtask

  // one cycle: compare before the edge, then advance the model
  task automatic cyc(string tag, bit do_chk = 1);
    #1;
    if (do_chk) begin
      chk(tag, "port A data", a_data, expect_rd(a_sel, a_wide));
      chk(tag, "port B data", b_data, expect_rd(b_sel, b_wide));
      chk("R5", "port A bad", {63'd0, a_bad}, {63'd0, a_wide & a_sel[0]});
      chk("R5", "port B bad", {63'd0, b_bad}, {63'd0, b_wide & b_sel[0]});
      chk("R4", "write bad", {63'd0, wr_bad}, {63'd0, wr_en & wr_wide & wr_sel[0]});
    end
    @(posedge clk);
    #1;
    if (rst) begin
      for (int k = 0; k < 32; k++) m[k] = '0;
    end else if (wr_ok()) begin
      m[wr_sel] = wr_data[31:0];
      if (wr_wide) m[wr_sel + 5'd1] = wr_data[63:32];
    end
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) m[k] = '0;
    rst = 1;
    setw(0, 0, 0, 0);
    setr(0, 0, 0, 0);
    @(negedge clk);
    cyc("R8", 0);
    cyc("R8", 0);
    rst = 0;
    // R8: cleared after reset
    setr(5'd0, 0, 5'd30, 1); cyc("R8");
    // R1 + R7: single write with same-cycle read, then plain read
    setw(1, 0, 5'd5, 64'hdead_0000_a5a5_1234); setr(5'd5, 0, 5'd4, 0); cyc("R7");
    setw(0, 0, 0, 0); setr(5'd5, 0, 5'd5, 0); cyc("R1");
    // R2 + R3: double write then double and half reads
    setw(1, 1, 5'd6, 64'h1111_2222_3333_4444); setr(5'd7, 0, 5'd6, 0); cyc("R2");
    setw(0, 0, 0, 0); setr(5'd6, 1, 5'd7, 0); cyc("R3");
    // R6: single write to odd half keeps even half
    setw(1, 0, 5'd7, 64'h0_9999_8888); setr(5'd6, 1, 5'd6, 0); cyc("R7");
    setw(0, 0, 0, 0); setr(5'd6, 1, 5'd6, 0); cyc("R6");
    // R4: odd-index double write is rejected
    setw(1, 0, 5'd9, 64'h0_0bad_cafe); cyc("R1");
    setw(1, 1, 5'd9, 64'hffff_eeee_dddd_cccc); setr(5'd9, 0, 5'd10, 0); cyc("R4");
    setw(0, 0, 0, 0); setr(5'd8, 1, 5'd9, 0); cyc("R4");
    // R5: odd-index double read
    setr(5'd7, 1, 5'd3, 1); cyc("R5");
    // R7: partial overlap, single write hits low half of a double read
    setw(1, 0, 5'd6, 64'h0_7777_6666); setr(5'd6, 1, 5'd2, 1); cyc("R7");
    // R10: idle write port with live data
    setw(0, 1, 5'd6, 64'h5555_5555_5555_5555); setr(5'd6, 1, 5'd5, 0); cyc("R10");
    setr(5'd6, 1, 5'd5, 0); cyc("R10");
    // R9: ports on different targets
    setr(5'd5, 0, 5'd6, 1); cyc("R9");
    // R8: reset after filling
    setw(1, 1, 5'd30, 64'habcd_ef01_2345_6789); cyc("R2");
    setw(0, 0, 0, 0); rst = 1; cyc("R8", 0);
    rst = 0; setr(5'd30, 1, 5'd5, 0); cyc("R8");
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      setw(1'($urandom), 1'($urandom), 5'($urandom), {$urandom, $urandom});
      setr(5'($urandom), 1'($urandom), 5'($urandom), 1'($urandom));
      cyc("R9");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule